// File: doc/BRIEF.md
# Cache Access Sequencer

This block decides, cycle by cycle, how each processor memory access to a unified cache is served. When a request arrives it can do one of four things. It can run a tag compare together with address translation. It can serve a sequential access from the line it just used, without a tag compare and without waking the MMU. It can hand the access to the external bus. Or, when there is no request, it can sit idle. The tag RAM, data RAM, MMU and bus are outside the block. The block drives their enables and request lines and takes back their hit, fault, translation-ready and beat-acknowledge responses.

Misses are sent down one of two paths. A cacheable read miss triggers a four-word line fill, fetched in order from the line base. If the translation is not yet held, the fill waits for it first. Uncacheable reads and unbuffered writes go out as a single-word bus transfer. The processor is stalled with a wait signal, and an access completes in any cycle where its request is valid and wait is low.

Top module: `cacheAccessCtrl`

## Requirements
- R1: After reset the bus request, wait, abort and fill write enables are low, and the first request is looked up with a tag compare (tagCheckEn high) even when it is flagged sequential.
- R2: A non-faulting request that is a cacheable read with tagHit high, or any buffered write, raises tagCheckEn and mmuEn in its cycle and completes in that cycle (cpuWait low, no bus request follows).
- R3: A sequential read, or a sequential buffered write, whose address bits above the line offset (bits 31:4 by default) equal those of the last completed cacheable access completes with tagCheckEn low, mmuEn low and cpuWait low, whatever tagHit is.
- R4: A sequential access into a different line is looked up (tagCheckEn high) rather than served on the fast path.
- R5: A lookup that misses, or an unbuffered write, raises cpuWait in the same cycle. busReq stays low in the following cycle and rises one cycle later (or later still when translation is pending).
- R6: An uncacheable read miss or an unbuffered write is one bus transfer: busLen is 1, busAddr is the request address, busWrite matches the access and fillWe stays zero. cpuWait drops in the cycle busAck is high.
- R7: A cacheable read miss requests busLen 4 at the line-aligned address. The k-th acknowledged beat (k from 0) raises fillWe bit k alone, and beats without busAck write nothing.
- R8: During a line fill, cpuWait is high until the beat carrying the requested word is acknowledged and low in that cycle. A new request made while the remaining beats arrive sees cpuWait high until the fill ends.
- R9: If xlatReady is low when the external access starts, mmuEn stays high and busReq stays low until xlatReady is seen high. The fill request begins the following cycle.
- R10: An mmuFault during a lookup raises abortPulse in that cycle with cpuWait and busReq low. The next sequential access is looked up, not served fast.
- R11: In a cycle with no request and no external access under way, tagCheckEn, mmuEn, busReq and cpuWait are all low.
- R12: Once a line fill has ended, a sequential read within the filled line takes the fast path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor requests a memory cycle |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqSeq | input | 1 | Access follows the previous one in address |
| reqBufferable | input | 1 | Write may complete through the write buffer |
| reqCacheable | input | 1 | Address is in cacheable memory |
| tagHit | input | 1 | Tag RAM reports a match for reqAddr |
| mmuFault | input | 1 | MMU rejects the access |
| xlatReady | input | 1 | Translation for the pending miss is held by the MMU |
| busAck | input | 1 | External bus completes one beat this cycle |
| tagCheckEn | output | 1 | Enable the tag compare |
| mmuEn | output | 1 | Activate the MMU |
| busReq | output | 1 | External transaction in progress |
| busAddr | output | ADDR_W | Start address of the external transaction |
| busLen | output | log2(LINE_WORDS)+1 | Beats in the transaction (1 or LINE_WORDS) |
| busWrite | output | 1 | External transaction is a write |
| fillWe | output | LINE_WORDS | One-hot write enable for the data RAM word being filled |
| cpuWait | output | 1 | Stall the processor |
| abortPulse | output | 1 | Current access is aborted by an MMU fault |

## Verification
The bench builds the block with its defaults: 32-bit addresses, four-word lines and four-byte words. With these values a line boundary falls every 16 bytes, so the fast path and a line crossing can both be reached with a handful of addresses. The four-beat fill lets the requested word land on the first beat, on the last beat, or after a gap with no acknowledge. A separate run holds translation back so the MMU stays busy across several cycles before the fill request is issued.

// File: rtl/cacheAccessCtrlPkg.sv
package cacheAccessCtrlPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SEQFAST,
    ST_STARTEXT,
    ST_XLATE,
    ST_FILL,
    ST_SINGLE
  } ctrlState_e;

  // control -> datapath
  typedef struct packed {
    logic latchReq;   // capture the request that goes external
    logic recordReq;  // note the line of the request completing now
    logic recordLat;  // note the line of the filled request
    logic clearLast;  // forget the remembered line
    logic beatClr;    // restart beat counting
    logic beatAdv;    // one beat acknowledged
    logic critSet;    // requested word has been delivered
    logic fillWrite;  // write the current beat into the data RAM
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic sameLine;
    logic latWrite;
    logic latCacheable;
    logic beatLast;
    logic beatIsCrit;
    logic critDone;
  } dpStatus_t;

endpackage

// File: rtl/cacheAccessDatapath.sv
module cacheAccessDatapath
  import cacheAccessCtrlPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic                  reqWrite,
  input  logic                  reqCacheable,
  input  dpStrobe_t             strobe,
  output dpStatus_t             status,
  output logic [ADDR_W-1:0]     busAddr,
  output logic [LINE_WORDS-1:0] fillWe
);

  localparam int OFF_W    = $clog2(WORD_BYTES);
  localparam int IDX_W    = $clog2(LINE_WORDS);
  localparam int LINE_LSB = OFF_W + IDX_W;
  localparam int TAG_W    = ADDR_W - LINE_LSB;

  logic [ADDR_W-1:0] latAddr;
  logic              latWrite;
  logic              latCacheable;
  logic [TAG_W-1:0]  lastLine;
  logic              lastValid;
  logic [IDX_W-1:0]  beatCnt;
  logic              critDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latAddr      <= '0;
      latWrite     <= 1'b0;
      latCacheable <= 1'b0;
    end else if (strobe.latchReq) begin
      latAddr      <= reqAddr;
      latWrite     <= reqWrite;
      latCacheable <= reqCacheable;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastLine  <= '0;
      lastValid <= 1'b0;
    end else if (strobe.recordReq) begin
      lastLine  <= reqAddr[ADDR_W-1:LINE_LSB];
      lastValid <= 1'b1;
    end else if (strobe.recordLat) begin
      lastLine  <= latAddr[ADDR_W-1:LINE_LSB];
      lastValid <= 1'b1;
    end else if (strobe.clearLast) begin
      lastValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt  <= '0;
      critDone <= 1'b0;
    end else if (strobe.beatClr) begin
      beatCnt  <= '0;
      critDone <= 1'b0;
    end else begin
      if (strobe.beatAdv) beatCnt <= beatCnt + 1'b1;
      if (strobe.critSet) critDone <= 1'b1;
    end
  end

  always_comb begin
    status.sameLine     = lastValid && (reqAddr[ADDR_W-1:LINE_LSB] == lastLine);
    status.latWrite     = latWrite;
    status.latCacheable = latCacheable;
    status.beatLast     = (beatCnt == IDX_W'(LINE_WORDS - 1));
    status.beatIsCrit   = (beatCnt == latAddr[LINE_LSB-1:OFF_W]);
    status.critDone     = critDone;
  end

  // line fills start at the line base, single transfers at the word itself
  assign busAddr = (latCacheable && !latWrite)
                   ? {latAddr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}}
                   : latAddr;

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_fillWe
    assign fillWe[w] = strobe.fillWrite && (beatCnt == IDX_W'(w));
  end

endmodule

// File: rtl/cacheAccessCtrlFsm.sv
module cacheAccessCtrlFsm
  import cacheAccessCtrlPkg::*;
#(
  parameter int LINE_WORDS = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             reqValid,
  input  logic                             reqWrite,
  input  logic                             reqSeq,
  input  logic                             reqBufferable,
  input  logic                             reqCacheable,
  input  logic                             tagHit,
  input  logic                             mmuFault,
  input  logic                             xlatReady,
  input  logic                             busAck,
  input  dpStatus_t                        status,
  output dpStrobe_t                        strobe,
  output logic                             tagCheckEn,
  output logic                             mmuEn,
  output logic                             busReq,
  output logic [$clog2(LINE_WORDS):0]      busLen,
  output logic                             busWrite,
  output logic                             cpuWait,
  output logic                             abortPulse
);

  localparam int LEN_W = $clog2(LINE_WORDS) + 1;

  ctrlState_e state, stateNext;

  logic ready;
  logic fastOk;
  logic servedNow;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_CHECK;
    else       state <= stateNext;
  end

  assign ready     = (state == ST_IDLE) || (state == ST_CHECK) || (state == ST_SEQFAST);
  assign fastOk    = reqSeq && status.sameLine && (!reqWrite || reqBufferable);
  assign servedNow = reqWrite ? reqBufferable : (reqCacheable && tagHit);

  always_comb begin
    stateNext  = state;
    strobe     = '0;
    tagCheckEn = 1'b0;
    mmuEn      = 1'b0;
    busReq     = 1'b0;
    busLen     = LEN_W'(1);
    busWrite   = 1'b0;
    cpuWait    = 1'b0;
    abortPulse = 1'b0;

    if (ready) begin
      if (!reqValid) begin
        stateNext = ST_IDLE;
      end else if (fastOk) begin
        stateNext = ST_SEQFAST;
      end else begin
        tagCheckEn = 1'b1;
        mmuEn      = 1'b1;
        if (mmuFault) begin
          abortPulse       = 1'b1;
          strobe.clearLast = 1'b1;
          stateNext        = ST_CHECK;
        end else if (servedNow) begin
          if (reqCacheable) strobe.recordReq = 1'b1;
          else              strobe.clearLast = 1'b1;
          stateNext = ST_CHECK;
        end else begin
          cpuWait         = 1'b1;
          strobe.latchReq = 1'b1;
          stateNext       = ST_STARTEXT;
        end
      end
    end else begin
      unique case (state)
        ST_STARTEXT: begin
          cpuWait        = 1'b1;
          strobe.beatClr = 1'b1;
          if (status.latCacheable && !status.latWrite)
            stateNext = xlatReady ? ST_FILL : ST_XLATE;
          else
            stateNext = ST_SINGLE;
        end
        ST_XLATE: begin
          cpuWait = 1'b1;
          mmuEn   = 1'b1;
          if (xlatReady) stateNext = ST_FILL;
        end
        ST_SINGLE: begin
          busReq   = 1'b1;
          busLen   = LEN_W'(1);
          busWrite = status.latWrite;
          cpuWait  = !busAck;
          if (busAck) begin
            strobe.clearLast = 1'b1;
            stateNext        = ST_CHECK;
          end
        end
        ST_FILL: begin
          busReq  = 1'b1;
          busLen  = LEN_W'(LINE_WORDS);
          cpuWait = status.critDone ? reqValid : !(busAck && status.beatIsCrit);
          if (busAck) begin
            strobe.fillWrite = 1'b1;
            strobe.beatAdv   = 1'b1;
            if (status.beatIsCrit) strobe.critSet = 1'b1;
            if (status.beatLast) begin
              strobe.recordLat = 1'b1;
              stateNext        = ST_CHECK;
            end
          end
        end
        default: stateNext = ST_CHECK;
      endcase
    end
  end

endmodule

// File: rtl/cacheAccessCtrl.sv
module cacheAccessCtrl
  import cacheAccessCtrlPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic                        reqWrite,
  input  logic                        reqSeq,
  input  logic                        reqBufferable,
  input  logic                        reqCacheable,
  input  logic                        tagHit,
  input  logic                        mmuFault,
  input  logic                        xlatReady,
  input  logic                        busAck,
  output logic                        tagCheckEn,
  output logic                        mmuEn,
  output logic                        busReq,
  output logic [ADDR_W-1:0]           busAddr,
  output logic [$clog2(LINE_WORDS):0] busLen,
  output logic                        busWrite,
  output logic [LINE_WORDS-1:0]       fillWe,
  output logic                        cpuWait,
  output logic                        abortPulse
);

  dpStrobe_t strobe;
  dpStatus_t status;

  cacheAccessCtrlFsm #(
    .LINE_WORDS(LINE_WORDS)
  ) u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .reqSeq       (reqSeq),
    .reqBufferable(reqBufferable),
    .reqCacheable (reqCacheable),
    .tagHit       (tagHit),
    .mmuFault     (mmuFault),
    .xlatReady    (xlatReady),
    .busAck       (busAck),
    .status       (status),
    .strobe       (strobe),
    .tagCheckEn   (tagCheckEn),
    .mmuEn        (mmuEn),
    .busReq       (busReq),
    .busLen       (busLen),
    .busWrite     (busWrite),
    .cpuWait      (cpuWait),
    .abortPulse   (abortPulse)
  );

  cacheAccessDatapath #(
    .ADDR_W    (ADDR_W),
    .LINE_WORDS(LINE_WORDS),
    .WORD_BYTES(WORD_BYTES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .reqAddr     (reqAddr),
    .reqWrite    (reqWrite),
    .reqCacheable(reqCacheable),
    .strobe      (strobe),
    .status      (status),
    .busAddr     (busAddr),
    .fillWe      (fillWe)
  );

endmodule

// File: rtl/cacheAccessCtrlChk.sv
module cacheAccessCtrlChk #(
  parameter int LINE_WORDS = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        reqValid,
  input logic                        tagCheckEn,
  input logic                        mmuEn,
  input logic                        busReq,
  input logic [$clog2(LINE_WORDS):0] busLen,
  input logic                        busAck,
  input logic [LINE_WORDS-1:0]       fillWe,
  input logic                        cpuWait,
  input logic                        abortPulse
);

  localparam int LEN_W = $clog2(LINE_WORDS) + 1;

  // R6
  bus_len_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busLen == LEN_W'(1) || busLen == LEN_W'(LINE_WORDS)));

  // R7
  fill_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fillWe));

  // R7
  fill_needs_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|fillWe) |-> (busReq && busAck && busLen == LEN_W'(LINE_WORDS)));

  // R10
  abort_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> (!busReq && !cpuWait && tagCheckEn));

  // R3
  fast_no_mmu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !tagCheckEn && !cpuWait && !busReq) |-> !mmuEn);

  // R5
  bus_after_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(cpuWait));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && !busReq && !cpuWait) |-> (!tagCheckEn && !mmuEn && !abortPulse));

endmodule

bind cacheAccessCtrl cacheAccessCtrlChk #(
  .LINE_WORDS(LINE_WORDS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .tagCheckEn(tagCheckEn),
  .mmuEn     (mmuEn),
  .busReq    (busReq),
  .busLen    (busLen),
  .busAck    (busAck),
  .fillWe    (fillWe),
  .cpuWait   (cpuWait),
  .abortPulse(abortPulse)
);

// File: tb/cacheAccessCtrl_tb.sv
module cacheAccessCtrl_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, reqSeq, reqBufferable, reqCacheable;
  logic [31:0] reqAddr;
  logic        tagHit, mmuFault, xlatReady, busAck;
  logic        tagCheckEn, mmuEn, busReq, busWrite, cpuWait, abortPulse;
  logic [31:0] busAddr;
  logic [2:0]  busLen;
  logic [3:0]  fillWe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cacheAccessCtrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSeq(reqSeq), .reqBufferable(reqBufferable),
    .reqCacheable(reqCacheable), .tagHit(tagHit), .mmuFault(mmuFault),
    .xlatReady(xlatReady), .busAck(busAck), .tagCheckEn(tagCheckEn),
    .mmuEn(mmuEn), .busReq(busReq), .busAddr(busAddr), .busLen(busLen),
    .busWrite(busWrite), .fillWe(fillWe), .cpuWait(cpuWait),
    .abortPulse(abortPulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // move to the next cycle: inputs change after the falling edge, checks follow 1 ns later
  task automatic nextCyc();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic idleIn();
    reqValid = 0; reqAddr = '0; reqWrite = 0; reqSeq = 0; reqBufferable = 0;
    reqCacheable = 0; tagHit = 0; mmuFault = 0; xlatReady = 1; busAck = 0;
  endtask

  task automatic req(input logic [31:0] a, input logic w, input logic s,
                     input logic b, input logic c, input logic hit);
    reqValid = 1; reqAddr = a; reqWrite = w; reqSeq = s; reqBufferable = b;
    reqCacheable = c; tagHit = hit; mmuFault = 0; busAck = 0;
  endtask

  task automatic testReset();
    settle();
    chk("R11 idle cpuWait", cpuWait, 0);
    chk("R11 idle tagCheckEn", tagCheckEn, 0);
    chk("R1 busReq after reset", busReq, 0);
    chk("R1 abort after reset", abortPulse, 0);
    chk("R1 fillWe after reset", fillWe, 0);
    nextCyc(); req(32'h40, 0, 1, 0, 1, 1); settle();
    chk("R1 first seq access looked up", tagCheckEn, 1);
    chk("R1 first access completes", cpuWait, 0);
    nextCyc(); idleIn();
  endtask

  task automatic testLookup();
    nextCyc(); req(32'h100, 0, 0, 0, 1, 1); settle();
    chk("R2 read hit tagCheckEn", tagCheckEn, 1);
    chk("R2 read hit mmuEn", mmuEn, 1);
    chk("R2 read hit no wait", cpuWait, 0);
    nextCyc(); req(32'h2000, 1, 0, 1, 0, 0); settle();
    chk("R2 buffered write tagCheckEn", tagCheckEn, 1);
    chk("R2 buffered write no wait", cpuWait, 0);
    nextCyc(); idleIn(); settle();
    chk("R2 buffered write no bus", busReq, 0);
  endtask

  task automatic testFast();
    nextCyc(); req(32'h100, 0, 0, 0, 1, 1); settle();
    chk("R3 opening lookup", tagCheckEn, 1);
    nextCyc(); req(32'h104, 0, 1, 0, 1, 0); settle();
    chk("R3 seq read no tag check", tagCheckEn, 0);
    chk("R3 seq read no mmu", mmuEn, 0);
    chk("R3 seq read no wait", cpuWait, 0);
    chk("R3 seq read no bus", busReq, 0);
    nextCyc(); req(32'h108, 1, 1, 1, 1, 0); settle();
    chk("R3 seq buffered write no tag check", tagCheckEn, 0);
    chk("R3 seq buffered write no wait", cpuWait, 0);
    nextCyc(); req(32'h110, 0, 1, 0, 1, 1); settle();
    chk("R4 line crossing looked up", tagCheckEn, 1);
    chk("R4 line crossing completes", cpuWait, 0);
    nextCyc(); idleIn();
  endtask

  task automatic testAbort();
    nextCyc(); req(32'h300, 0, 0, 0, 1, 1); settle();
    nextCyc(); req(32'h304, 0, 0, 0, 1, 1); mmuFault = 1; settle();
    chk("R10 abort raised", abortPulse, 1);
    chk("R10 abort no wait", cpuWait, 0);
    chk("R10 abort no bus", busReq, 0);
    nextCyc(); req(32'h308, 0, 1, 0, 1, 1); settle();
    chk("R10 abort one cycle", abortPulse, 0);
    chk("R10 seq after abort looked up", tagCheckEn, 1);
    nextCyc(); idleIn();
  endtask

  task automatic testSingle();
    nextCyc(); req(32'h404, 0, 0, 0, 0, 0); settle();
    chk("R5 miss waits at once", cpuWait, 1);
    chk("R5 no bus in miss cycle", busReq, 0);
    nextCyc(); settle();
    chk("R5 start cycle waits", cpuWait, 1);
    chk("R5 start cycle no bus", busReq, 0);
    nextCyc(); settle();
    chk("R6 single busReq", busReq, 1);
    chk("R6 single busLen", busLen, 1);
    chk("R6 single busAddr", busAddr, 32'h404);
    chk("R6 single read busWrite", busWrite, 0);
    chk("R6 waits before ack", cpuWait, 1);
    nextCyc(); busAck = 1; settle();
    chk("R6 released on ack", cpuWait, 0);
    chk("R6 no fill write", fillWe, 0);
    nextCyc(); idleIn(); settle();
    chk("R6 bus ends", busReq, 0);
    nextCyc(); req(32'h508, 1, 0, 0, 1, 1); settle();
    chk("R5 unbuffered write waits", cpuWait, 1);
    nextCyc(); settle();
    nextCyc(); busAck = 1; settle();
    chk("R6 write busWrite", busWrite, 1);
    chk("R6 write busLen", busLen, 1);
    chk("R6 write busAddr", busAddr, 32'h508);
    chk("R6 write released", cpuWait, 0);
    nextCyc(); idleIn(); settle();
    chk("R6 write bus ends", busReq, 0);
  endtask

  task automatic testFill();
    nextCyc(); req(32'h60C, 0, 0, 0, 1, 0); settle();
    chk("R5 fill miss waits", cpuWait, 1);
    nextCyc(); settle();
    chk("R5 fill start no bus", busReq, 0);
    nextCyc(); busAck = 1; settle();
    chk("R7 fill busLen", busLen, 4);
    chk("R7 fill line base", busAddr, 32'h600);
    chk("R7 beat0 we", fillWe, 4'b0001);
    chk("R8 waits before word 3", cpuWait, 1);
    nextCyc(); busAck = 1; settle();
    chk("R7 beat1 we", fillWe, 4'b0010);
    nextCyc(); busAck = 0; settle();
    chk("R7 gap no write", fillWe, 4'b0000);
    chk("R7 gap bus held", busReq, 1);
    nextCyc(); busAck = 1; settle();
    chk("R7 beat2 we", fillWe, 4'b0100);
    chk("R8 still waiting", cpuWait, 1);
    nextCyc(); busAck = 1; settle();
    chk("R7 beat3 we", fillWe, 4'b1000);
    chk("R8 released on word 3", cpuWait, 0);
    nextCyc(); req(32'h604, 0, 1, 0, 1, 0); settle();
    chk("R12 filled line fast", tagCheckEn, 0);
    chk("R12 filled line no wait", cpuWait, 0);
    chk("R12 no bus", busReq, 0);
    nextCyc(); idleIn();
  endtask

  task automatic testCrit();
    nextCyc(); req(32'h700, 0, 0, 0, 1, 0); settle();
    nextCyc(); settle();
    nextCyc(); busAck = 1; settle();
    chk("R8 word 0 released", cpuWait, 0);
    chk("R7 crit beat0 we", fillWe, 4'b0001);
    nextCyc(); req(32'h800, 0, 0, 0, 1, 1); busAck = 1; settle();
    chk("R8 new request held", cpuWait, 1);
    chk("R8 new request not looked up", tagCheckEn, 0);
    chk("R7 crit beat1 we", fillWe, 4'b0010);
    nextCyc(); busAck = 1; settle();
    chk("R8 held beat2", cpuWait, 1);
    nextCyc(); busAck = 1; settle();
    chk("R8 held last beat", cpuWait, 1);
    chk("R7 crit beat3 we", fillWe, 4'b1000);
    nextCyc(); busAck = 0; settle();
    chk("R8 served after fill", cpuWait, 0);
    chk("R8 lookup after fill", tagCheckEn, 1);
    chk("R8 bus done", busReq, 0);
    nextCyc(); idleIn();
  endtask

  task automatic testXlat();
    nextCyc(); req(32'h900, 0, 0, 0, 1, 0); xlatReady = 0; settle();
    nextCyc(); settle();
    chk("R9 start waits", cpuWait, 1);
    nextCyc(); settle();
    chk("R9 mmu busy", mmuEn, 1);
    chk("R9 no bus yet", busReq, 0);
    chk("R9 waiting", cpuWait, 1);
    nextCyc(); xlatReady = 1; settle();
    chk("R9 mmu busy on ready", mmuEn, 1);
    chk("R9 no bus on ready", busReq, 0);
    nextCyc(); busAck = 1; settle();
    chk("R9 fill begins", busReq, 1);
    chk("R9 fill length", busLen, 4);
    chk("R9 mmu off in fill", mmuEn, 0);
    chk("R8 word 0 at beat 0", cpuWait, 0);
    nextCyc(); reqValid = 0; busAck = 1;
    nextCyc(); busAck = 1;
    nextCyc(); busAck = 1;
    nextCyc(); idleIn(); settle();
    chk("R9 fill over", busReq, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idleIn();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testLookup();
    testFast();
    testAbort();
    testSingle();
    testFill();
    testCrit();
    testXlat();
    nextCyc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule